// File: doc/BRIEF.md
# Packet-Aware Receive Buffer with Overflow Discard

This block sits between an upstream byte source that cannot be stalled and a downstream port that takes bytes under a valid/ready handshake. Each byte is stored with two flags, one for start of packet and one for end of packet. The buffer holds back its output until enough bytes are queued or until a whole packet end is stored. One clock drives both the write side and the read side.

When a byte arrives and the buffer is full, the oldest stored byte is thrown away to make room. The block then keeps dropping bytes from the head, one per cycle, until a start-of-packet byte is at the head. This stops the tail of one packet from being joined onto the start of another. If the downstream side had already received part of the damaged packet, the block closes that packet with a single beat that has both the error and end flags set. Each overflow sets a sticky alarm, which stays set until a clear input is pulsed.

Top module: `pkt_rx_fifo`

## Requirements
- R1: The buffer holds 256 entries. 256 writes with no reads cause no overflow and leave `alarm` low.
- R2: While no end-of-packet byte is stored, `out_valid` stays low as long as occupancy is below `wmark`. It goes high once occupancy reaches `wmark`.
- R3: When at least one end-of-packet byte is stored, `out_valid` is high whenever the buffer is not empty, whatever the value of `wmark`.
- R4: Bytes leave the buffer in write order with their start and end flags unchanged. A byte is consumed only on a cycle where `out_valid` and `out_ready` are both high. While the output is stalled and no overflow occurs, the presented byte does not change.
- R5: A write into a full buffer drops only the oldest entry when the next entry is a start of packet. The new byte is kept.
- R6: After an overflow drop, bytes keep being dropped from the head until a start-of-packet byte is at the head. The next normal byte delivered carries `out_sop`=1.
- R7: An overflow that happens while a packet is partly delivered produces exactly one beat with `out_err`=1, `out_eop`=1, `out_sop`=0 and `out_data`=0. Delivery then resumes at the next start of packet. An overflow that happens when no packet is partly delivered produces no error beat.
- R8: Every overflow sets `alarm`. `alarm` stays set until `alarm_clr` is high on a clock edge with no overflow. If both happen on the same edge, the set wins.
- R9: If the buffer runs empty in the middle of a packet, `out_valid` goes low, no error beat is produced and `alarm` does not change.
- R10: After a synchronous reset, the buffer is empty, `out_valid` is low and `alarm` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Write strobe; always accepted |
| in_data | input | 8 | Byte to store |
| in_sop | input | 1 | Byte starts a packet |
| in_eop | input | 1 | Byte ends a packet |
| wmark | input | 9 | Occupancy threshold that releases output |
| out_ready | input | 1 | Downstream accepts the presented beat |
| out_valid | output | 1 | A beat is presented |
| out_data | output | 8 | Presented byte (0 on an error beat) |
| out_sop | output | 1 | Presented byte starts a packet |
| out_eop | output | 1 | Presented byte ends a packet |
| out_err | output | 1 | Beat closes a packet damaged by overflow |
| alarm_clr | input | 1 | Clears the sticky overflow alarm |
| alarm | output | 1 | Sticky overflow indication |

## Verification
The hardest case to reach is an overflow that lands in the middle of a packet that is already partly delivered. It needs a packet that has started on the output, a stalled reader, and a buffer filled to exactly 256 entries with continuation bytes. The bench reads three bytes of a packet, then drops `out_ready` and tops the buffer up byte by byte to full. It then writes a new start-of-packet byte. It waits long enough for the whole head discard to finish before releasing the reader. The scoreboard then expects one error-plus-end beat, followed directly by the new packet.

// File: rtl/pkf_pkg.sv
// Shared types for the packet-aware receive buffer.
// Assumes a fixed 8-bit payload per stored entry.
package pkf_pkg;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic              sop;
        logic              eop;
        logic [DATA_W-1:0] data;
    } rx_entry_t;
endpackage

// File: rtl/pkf_store.sv
// Circular storage for the receive buffer: one write port and one head pop.
// The head entry is read combinationally. Assumes DEPTH is a power of two,
// and that the controller pops on any cycle where it writes into a full buffer.
module pkf_store
    import pkf_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  rx_entry_t                 wr_entry,
    input  logic                      pop,
    output rx_entry_t                 head,
    output logic [$clog2(DEPTH):0]    count,
    output logic                      empty,
    output logic                      full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    rx_entry_t       mem [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;
    logic [CW-1:0]   cnt;

    // Entry array write; contents need no reset.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_entry;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + AW'(1);
            if (pop)   rd_ptr <= rd_ptr + AW'(1);
            cnt <= cnt + CW'(wr_en) - CW'(pop);
        end
    end

    // Head view and fill flags.
    always_comb begin
        head  = mem[rd_ptr];
        count = cnt;
        empty = (cnt == '0);
        full  = (cnt == CW'(DEPTH));
    end

    p_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    p_full_write_pops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |-> pop);
    p_no_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/pkf_ctrl.sv
// Read gating, overflow discard and error-beat control for the receive buffer.
// Decides each cycle whether the head is delivered, dropped, or held. It also
// keeps the stored end-of-packet count and the sticky alarm.
// Assumes the storage pops exactly once on any cycle where pop is high.
module pkf_ctrl
    import pkf_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    wr_eop,
    input  rx_entry_t               head,
    input  logic [$clog2(DEPTH):0]  count,
    input  logic                    empty,
    input  logic                    full,
    input  logic [$clog2(DEPTH):0]  wmark,
    input  logic                    out_ready,
    input  logic                    alarm_clr,
    output logic                    pop,
    output logic                    out_valid,
    output rx_entry_t               out_beat,
    output logic                    out_err,
    output logic                    alarm
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic          discarding;
    logic          err_pend;
    logic          mid_pkt;
    logic          alarm_q;
    logic [CW-1:0] eop_cnt;

    logic disc_active;
    logic gate_ok;
    logic norm_valid;
    logic rd_fire;
    logic err_fire;
    logic ovf;

    // Per-cycle decisions on delivery, discard and overflow.
    always_comb begin
        disc_active = discarding && !empty && !head.sop;
        gate_ok     = !empty && ((count >= wmark) || (eop_cnt != '0));
        norm_valid  = gate_ok && !disc_active && !err_pend;
        rd_fire     = norm_valid && out_ready;
        err_fire    = err_pend && out_ready;
        ovf         = wr_en && full && !rd_fire && !disc_active;
        pop         = rd_fire || disc_active || ovf;
    end

    // Output beat: error closure takes precedence over stored data.
    always_comb begin
        out_valid = err_pend || norm_valid;
        if (err_pend) begin
            out_beat = '{sop: 1'b0, eop: 1'b1, data: '0};
            out_err  = 1'b1;
        end else begin
            out_beat = head;
            out_err  = 1'b0;
        end
        alarm = alarm_q;
    end

    // Discard mode: entered on overflow, left once a packet start is at the head.
    always_ff @(posedge clk) begin
        if (!rst_n)                                discarding <= 1'b0;
        else if (ovf)                              discarding <= 1'b1;
        else if (discarding && (empty || head.sop)) discarding <= 1'b0;
    end

    // Tracks whether a packet is open on the output side.
    always_ff @(posedge clk) begin
        if (!rst_n)        mid_pkt <= 1'b0;
        else if (err_fire) mid_pkt <= 1'b0;
        else if (rd_fire) begin
            if (head.eop)      mid_pkt <= 1'b0;
            else if (head.sop) mid_pkt <= 1'b1;
        end
    end

    // One pending error-plus-end beat per damaged open packet.
    always_ff @(posedge clk) begin
        if (!rst_n)              err_pend <= 1'b0;
        else if (err_fire)       err_pend <= 1'b0;
        else if (ovf && mid_pkt) err_pend <= 1'b1;
    end

    // Number of stored end-of-packet entries.
    always_ff @(posedge clk) begin
        if (!rst_n) eop_cnt <= '0;
        else        eop_cnt <= eop_cnt + CW'(wr_en && wr_eop) - CW'(pop && head.eop);
    end

    // Sticky alarm; a new overflow beats a clear on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         alarm_q <= 1'b0;
        else if (ovf)       alarm_q <= 1'b1;
        else if (alarm_clr) alarm_q <= 1'b0;
    end

    p_eop_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eop_cnt <= count);
    p_err_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> (out_beat.eop && !out_beat.sop));
    p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pend && !out_ready) |=> (out_valid && out_err));
    p_alarm_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_q) |-> $past(wr_en && full));
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err && !out_ready && !(wr_en && full))
        |=> ($stable(out_beat.data) && $stable(out_beat.sop)));
endmodule

// File: rtl/pkt_rx_fifo.sv
// Packet-aware receive buffer: stores flagged bytes, releases them at a
// threshold or on a stored packet end, and discards from the head on overflow
// up to the next packet start. Single clock, synchronous active-low reset.
module pkt_rx_fifo
    import pkf_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [DATA_W-1:0]       in_data,
    input  logic                    in_sop,
    input  logic                    in_eop,
    input  logic [$clog2(DEPTH):0]  wmark,
    input  logic                    out_ready,
    output logic                    out_valid,
    output logic [DATA_W-1:0]       out_data,
    output logic                    out_sop,
    output logic                    out_eop,
    output logic                    out_err,
    input  logic                    alarm_clr,
    output logic                    alarm
);
    localparam int CW = $clog2(DEPTH) + 1;

    rx_entry_t     wr_entry;
    rx_entry_t     head;
    rx_entry_t     beat;
    logic [CW-1:0] count;
    logic          empty;
    logic          full;
    logic          pop;

    // Pack the incoming byte with its flags.
    always_comb wr_entry = '{sop: in_sop, eop: in_eop, data: in_data};

    pkf_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (in_valid),
        .wr_entry (wr_entry),
        .pop      (pop),
        .head     (head),
        .count    (count),
        .empty    (empty),
        .full     (full)
    );

    pkf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (in_valid),
        .wr_eop    (in_eop),
        .head      (head),
        .count     (count),
        .empty     (empty),
        .full      (full),
        .wmark     (wmark),
        .out_ready (out_ready),
        .alarm_clr (alarm_clr),
        .pop       (pop),
        .out_valid (out_valid),
        .out_beat  (beat),
        .out_err   (out_err),
        .alarm     (alarm)
    );

    // Unpack the presented beat onto the port.
    always_comb begin
        out_data = beat.data;
        out_sop  = beat.sop;
        out_eop  = beat.eop;
    end
endmodule

// File: tb/tb_pkt_rx_fifo.sv
module tb_pkt_rx_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_sop = 1'b0;
    logic       in_eop = 1'b0;
    logic [8:0] wmark = '0;
    logic       out_ready = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_sop;
    logic       out_eop;
    logic       out_err;
    logic       alarm_clr = 1'b0;
    logic       alarm;

    int checks = 0;
    int fails = 0;
    logic [10:0] expq [$];   // {err, sop, eop, data}

    always #10 clk = ~clk;

    pkt_rx_fifo dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop), .wmark(wmark), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
        .out_eop(out_eop), .out_err(out_err), .alarm_clr(alarm_clr), .alarm(alarm)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic err, input logic sop, input logic eop, input logic [7:0] d);
        expq.push_back({err, sop, eop, d});
    endtask

    task automatic wr(input logic [7:0] d, input logic sop, input logic eop);
        in_valid = 1'b1; in_data = d; in_sop = sop; in_eop = eop;
        @(posedge clk); #1;
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic drain(input string req);
        int t;
        t = 0;
        out_ready = 1'b1;
        while (expq.size() != 0 && t < 3000) begin
            @(posedge clk); #1;
            t++;
        end
        out_ready = 1'b0;
        chk({req, " drain complete"}, expq.size(), 0);
    endtask

    // Monitor: compares every handshake against the scoreboard queue (R4).
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            logic [10:0] e;
            checks++;
            if (expq.size() == 0) begin
                fails++;
                $display("FAIL R4 unexpected beat actual=%0h expected=none",
                         {out_err, out_sop, out_eop, out_data});
            end else begin
                e = expq.pop_front();
                if ({out_err, out_sop, out_eop, out_data} !== e) begin
                    fails++;
                    $display("FAIL R4/R7 beat actual=%0h expected=%0h",
                             {out_err, out_sop, out_eop, out_data}, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R10 reset state
        chk("R10 out_valid", out_valid, 0);
        chk("R10 alarm", alarm, 0);

        // R2 threshold release
        wmark = 9'd4;
        wr(8'h10, 1, 0); wr(8'h11, 0, 0); wr(8'h12, 0, 0);
        chk("R2 below wmark", out_valid, 0);
        wr(8'h13, 0, 0);
        chk("R2 at wmark", out_valid, 1);
        wr(8'h14, 0, 1);
        push(0,1,0,8'h10); push(0,0,0,8'h11); push(0,0,0,8'h12);
        push(0,0,0,8'h13); push(0,0,1,8'h14);
        drain("R4");

        // R3 stored end releases output below wmark
        wmark = 9'd200;
        wr(8'h20, 1, 0);
        chk("R3 no eop yet", out_valid, 0);
        wr(8'h21, 0, 1);
        chk("R3 eop stored", out_valid, 1);
        push(0,1,0,8'h20); push(0,0,1,8'h21);
        drain("R3");

        // R1 full capacity, no overflow
        wmark = 9'd256;
        wr(8'h00, 1, 0);
        for (int i = 1; i < 255; i++) wr(8'(i), 0, 0);
        chk("R1 255 entries below wmark", out_valid, 0);
        wr(8'hFF, 0, 0);
        chk("R1 256 entries at wmark", out_valid, 1);
        chk("R1 no alarm when full", alarm, 0);

        // R6 overflow with nothing delivered: discard to next start, no error beat
        wr(8'hB0, 1, 0);
        chk("R8 alarm on overflow", alarm, 1);
        idle(300);
        chk("R6 only new start left", out_valid, 0);
        wr(8'hB1, 0, 0); wr(8'hB2, 0, 1);
        push(0,1,0,8'hB0); push(0,0,0,8'hB1); push(0,0,1,8'hB2);
        drain("R6");
        chk("R8 alarm sticky", alarm, 1);
        alarm_clr = 1'b1; idle(1); alarm_clr = 1'b0;
        chk("R8 alarm cleared", alarm, 0);

        // R5 only the oldest is dropped when the next entry starts a packet
        for (int i = 0; i < 256; i++) wr(8'(i), 1, 1);
        chk("R5 full no alarm", alarm, 0);
        wr(8'hAA, 1, 1);
        chk("R5 alarm", alarm, 1);
        for (int i = 1; i < 256; i++) push(0,1,1,8'(i));
        push(0,1,1,8'hAA);
        idle(2);
        drain("R5");
        alarm_clr = 1'b1; idle(1); alarm_clr = 1'b0;

        // R7 overflow while a packet is partly delivered
        wmark = 9'd0;
        wr(8'hC0, 1, 0);
        for (int i = 1; i < 10; i++) wr(8'hC0 + 8'(i), 0, 0);
        push(0,1,0,8'hC0); push(0,0,0,8'hC1); push(0,0,0,8'hC2);
        out_ready = 1'b1; idle(3); out_ready = 1'b0;
        chk("R7 three delivered", expq.size(), 0);
        for (int i = 0; i < 249; i++) wr(8'h50, 0, 0);
        chk("R7 full no alarm", alarm, 0);
        wr(8'hD0, 1, 0);
        chk("R8 alarm second overflow", alarm, 1);
        idle(300);
        chk("R7 error beat valid", out_valid, 1);
        chk("R7 error flag", out_err, 1);
        wr(8'hD1, 0, 1);
        push(1,0,1,8'h00); push(0,1,0,8'hD0); push(0,0,1,8'hD1);
        drain("R7");
        alarm_clr = 1'b1; idle(1); alarm_clr = 1'b0;

        // R9 underflow mid-packet is silent
        out_ready = 1'b1;
        push(0,1,0,8'hE0); push(0,0,0,8'hE1);
        wr(8'hE0, 1, 0); wr(8'hE1, 0, 0);
        idle(3);
        chk("R9 empty mid-packet valid", out_valid, 0);
        chk("R9 no error", out_err, 0);
        chk("R9 no alarm", alarm, 0);
        push(0,0,1,8'hE2);
        wr(8'hE2, 0, 1);
        drain("R9");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule